// File: doc/BRIEF.md
# Per-Requester Stride Miss Prefetcher

This block observes cache misses and predicts the next blocks a requester will touch. Each miss carries an address and a requester number. The block keeps a short history for each requester: the block address of its most recent miss and the one before it. A new miss yields two strides, one from the current block to the last miss and one from the last miss to the miss before it. When these two strides are equal, the block emits a burst of prefetch addresses. Each address lies a whole number of strides ahead of the current block.

Misses enter through a valid/ready port. Prefetch requests leave through a valid/ready port, and each one carries an address and a fixed delay tag. The miss port is closed while a burst is being emitted. The block tests one candidate per cycle and advances to the next candidate only when the consumer accepts the current one. With page-stop enabled, a burst ends at the first candidate that falls outside the page of the triggering miss. The prefetches skipped this way are added to a running counter.

Top module: `stride_prefetcher`

## Requirements
- R1: Every miss address has its block-offset bits (the low 6 bits by default) cleared before any use, so emitted addresses are always block aligned.
- R2: History is kept independently for each of REQ_N requesters (default 64). A miss from one requester never changes the strides seen by another requester.
- R3: When `cfg_use_req` is 0, every miss is handled as if its requester number were 0.
- R4: Every accepted miss shifts its requester's history, whether or not it triggers prefetches. The older slot takes the previous last address, and the last slot takes the new block address.
- R5: A miss triggers a burst only when (block − last) equals (last − older), with both differences taken modulo 2^AW. The burst emits block + d·stride for d = 1, 2, …, `cfg_degree`, in increasing d. A degree of 0 emits nothing.
- R6: With `cfg_page_stop` at 1, the first candidate whose page number (address bits above the low 12 by default) differs from the triggering block's page ends the burst. Nothing after it is emitted for that miss. With `cfg_page_stop` at 0, there is no page limit.
- R7: A burst cut at step d increases `span_count` by `cfg_degree` − d + 1. The counter changes at no other time.
- R8: Every emitted prefetch carries `cfg_latency` on `pf_delay`.
- R9: `miss_ready` is low while a burst is in progress. A stalled prefetch (valid high, ready low) keeps its address until it is accepted.
- R10: After reset all history entries are zero, `span_count` is zero and no prefetch is pending. Strides are measured against those zeros, and a matching zero stride emits prefetches of the same block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss event offered |
| miss_ready | output | 1 | Block can accept a miss |
| miss_addr | input | AW | Miss byte address |
| miss_req | input | log2(REQ_N) | Requester number |
| cfg_degree | input | DEG_W | Maximum prefetches per miss |
| cfg_latency | input | LAT_W | Delay tag attached to each prefetch |
| cfg_page_stop | input | 1 | Stop bursts at page boundary |
| cfg_use_req | input | 1 | Use requester number (0: all share entry 0) |
| pf_valid | output | 1 | Prefetch request offered |
| pf_ready | input | 1 | Consumer accepts prefetch |
| pf_addr | output | AW | Prefetch block address |
| pf_delay | output | LAT_W | Delay tag of the prefetch |
| span_count | output | CNT_W | Prefetches skipped at page boundaries |

## Verification
Two things happen in the same cycle when a miss is accepted: its requester's history is rewritten, and the burst starts from the strides read out of that same history. The bench sends back-to-back misses from one requester, then interleaves misses from two others, so that every shift feeds the next trigger decision directly. A reference model in the bench tracks the history, and a scoreboard queue holds the predicted addresses. The second overlap is a page cut: the counter update and the closing of the burst happen together, and the miss driver is already waiting for `miss_ready` to rise. The bench judges this through the final counter value and through the order of the prefetches that follow. Consumer stalls that shift with a counter stretch every burst, to check that addresses are held while the consumer is not ready.

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int AW         = 32,
  parameter int BLK_BYTES  = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int REQ_N      = 64,
  parameter int DEG_W      = 4,
  parameter int LAT_W      = 16,
  parameter int CNT_W      = 16,
  localparam int IDW = $clog2(REQ_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [AW-1:0]    miss_addr,
  input  logic [IDW-1:0]   miss_req,
  input  logic [DEG_W-1:0] cfg_degree,
  input  logic [LAT_W-1:0] cfg_latency,
  input  logic             cfg_page_stop,
  input  logic             cfg_use_req,
  output logic             pf_valid,
  input  logic             pf_ready,
  output logic [AW-1:0]    pf_addr,
  output logic [LAT_W-1:0] pf_delay,
  output logic [CNT_W-1:0] span_count
);
  localparam int OFS = $clog2(BLK_BYTES);
  localparam int PG  = $clog2(PAGE_BYTES);

  logic [AW-1:0]    last_q [REQ_N];
  logic [AW-1:0]    older_q[REQ_N];
  logic             busy_q;
  logic [AW-1:0]    base_q, stride_q, cand_q;
  logic [DEG_W-1:0] step_q;

  logic [IDW-1:0] rid;
  logic [AW-1:0]  blk, new_s, old_s;
  logic           take, cut, hit;

  assign rid   = cfg_use_req ? miss_req : '0;
  assign blk   = {miss_addr[AW-1:OFS], {OFS{1'b0}}};
  assign new_s = blk - last_q[rid];
  assign old_s = last_q[rid] - older_q[rid];
  assign take  = miss_valid && miss_ready;
  assign hit   = (new_s == old_s) && (cfg_degree != '0);
  assign cut   = cfg_page_stop && (cand_q[AW-1:PG] != base_q[AW-1:PG]);

  assign miss_ready = !busy_q;
  assign pf_valid   = busy_q && !cut;
  assign pf_addr    = cand_q;
  assign pf_delay   = cfg_latency;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REQ_N; i++) begin
        last_q[i]  <= '0;
        older_q[i] <= '0;
      end
    end else if (take) begin
      older_q[rid] <= last_q[rid];
      last_q[rid]  <= blk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      base_q     <= '0;
      stride_q   <= '0;
      cand_q     <= '0;
      step_q     <= '0;
      span_count <= '0;
    end else if (!busy_q) begin
      if (take && hit) begin
        busy_q   <= 1'b1;
        base_q   <= blk;
        stride_q <= new_s;
        cand_q   <= blk + new_s;
        step_q   <= DEG_W'(1);
      end
    end else if (cut) begin
      busy_q     <= 1'b0;
      span_count <= span_count + CNT_W'(cfg_degree) - CNT_W'(step_q) + CNT_W'(1);
    end else if (pf_ready) begin
      if (step_q == cfg_degree) busy_q <= 1'b0;
      step_q <= step_q + DEG_W'(1);
      cand_q <= cand_q + stride_q;
    end
  end

  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr)); // R9

  AST_NEXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready |=> !pf_valid || (pf_addr == $past(pf_addr) + stride_q)); // R5

  AST_CUT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !pf_valid |=> !busy_q && miss_ready); // R6

  AST_SPAN_ONLY_AT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(span_count) |-> $past(busy_q && !pf_valid)); // R7

  AST_IDLE_NO_PF: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !pf_valid); // R9

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr[OFS-1:0] == '0); // R1
endmodule

// File: tb/stride_prefetcher_bench.sv
module stride_prefetcher_bench;
  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, miss_ready;
  logic [31:0] miss_addr = 0;
  logic [5:0] miss_req = 0;
  logic [3:0] cfg_degree = 4;
  logic [15:0] cfg_latency = 16'd7;
  logic cfg_page_stop = 1, cfg_use_req = 1;
  logic pf_valid, pf_ready = 0;
  logic [31:0] pf_addr;
  logic [15:0] pf_delay;
  logic [15:0] span_count;

  stride_prefetcher u_stride_prefetcher (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, exp_span = 0, rcnt = 0;
  logic [31:0] m_last[64], m_older[64];
  logic [31:0] expq[$];
  string tag = "R10";

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic model(logic [31:0] a, logic [5:0] q);
    logic [31:0] b, ns, os, c;
    int id;
    b  = a & ~32'h3F;
    id = cfg_use_req ? int'(q) : 0;
    ns = b - m_last[id];
    os = m_last[id] - m_older[id];
    m_older[id] = m_last[id];
    m_last[id]  = b;
    if (ns == os) begin
      for (int d = 1; d <= int'(cfg_degree); d++) begin
        c = b + ns * d;
        if (cfg_page_stop && c[31:12] != b[31:12]) begin
          exp_span += int'(cfg_degree) - d + 1;
          break;
        end
        expq.push_back(c);
      end
    end
  endtask

  task automatic send(logic [31:0] a, logic [5:0] q);
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    model(a, q);
    miss_valid = 1; miss_addr = a; miss_req = q;
    @(posedge clk); #1;
    miss_valid = 0;
  endtask

  task automatic drain(string r);
    int n = 0;
    while ((expq.size() != 0 || !miss_ready) && n < 2000) begin
      @(negedge clk); n++;
    end
    chk(expq.size() == 0, r, 32'(expq.size()), 0);
    chk(span_count == 16'(exp_span), r, 32'(span_count), 32'(exp_span));
  endtask

  always @(posedge clk) begin
    #1; rcnt++;
    pf_ready = (rcnt % 3) != 0;
  end

  always @(negedge clk) if (rst_n && pf_valid) begin
    chk(!miss_ready, "R9", 32'(miss_ready), 0);
    if (pf_ready) begin
      if (expq.size() == 0) chk(0, tag, pf_addr, 32'hX);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(pf_addr == e, tag, pf_addr, e);
        chk(pf_delay == cfg_latency, "R8", 32'(pf_delay), 32'(cfg_latency));
      end
    end
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_last[i] = 0; m_older[i] = 0; end
    #1;
    chk(miss_ready == 1, "R10", 32'(miss_ready), 1);
    chk(pf_valid == 0, "R10", 32'(pf_valid), 0);
    chk(span_count == 0, "R10", 32'(span_count), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R10"; send(32'h0000_0011, 6'd5); drain("R10");
    tag = "R1";  send(32'h0000_100D, 6'd1); send(32'h0000_1047, 6'd1);
                 send(32'h0000_10BF, 6'd1); drain("R1");
    tag = "R2";  send(32'h0000_4000, 6'd2); send(32'h0000_8000, 6'd3);
                 send(32'h0000_4080, 6'd2); send(32'h0000_8100, 6'd3);
                 send(32'h0000_4100, 6'd2); send(32'h0000_8200, 6'd3);
                 send(32'h0000_4180, 6'd2); drain("R2");
    tag = "R4";  send(32'h0000_5000, 6'd7); send(32'h0000_6000, 6'd7);
                 send(32'h0000_6000, 6'd7); send(32'h0000_6000, 6'd7); drain("R4");
    tag = "R6";  send(32'h0000_2F00, 6'd4); send(32'h0000_2F40, 6'd4);
                 send(32'h0000_2F80, 6'd4); drain("R7");
    send(32'h0000_7040, 6'd9); send(32'h0000_7000, 6'd9); send(32'h0000_6FC0, 6'd9);
    drain("R6");
    cfg_page_stop = 0;
    send(32'h0000_9F00, 6'd4); send(32'h0000_9F40, 6'd4); send(32'h0000_9F80, 6'd4);
    drain("R6");
    cfg_page_stop = 1;
    tag = "R3"; cfg_use_req = 0;
    send(32'h0001_0000, 6'd11); send(32'h0001_0100, 6'd12); send(32'h0001_0200, 6'd13);
    drain("R3");
    cfg_use_req = 1;
    tag = "R5"; cfg_degree = 0;
    send(32'h0002_0000, 6'd20); send(32'h0002_0040, 6'd20); send(32'h0002_0080, 6'd20);
    drain("R5");
    cfg_degree = 9; cfg_latency = 16'h0ABC; tag = "R8";
    send(32'h0002_00C0, 6'd20); drain("R8");
    cfg_degree = 15; tag = "R7";
    send(32'h0003_0E00, 6'd30); send(32'h0003_0E80, 6'd30); send(32'h0003_0F00, 6'd30);
    drain("R7");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule